// File: doc/BRIEF.md
# Three-Channel Serial Register Front End

This block is the register-side face of three serial channels. A processor reaches it over a simple single-cycle request bus that carries a byte offset, a size flag and write data. The block decodes the offset into one register of one channel and checks whether the access size suits that register. Write data that would touch protected bits is refused. Each request gets exactly one registered response in the next cycle, and that response either returns read data or reports an error.

Each channel holds a 16-bit control word, an 8-bit interrupt-mode byte, a transmit byte, a receive byte and a status word. The only status bit in use is the receive-ready flag. The last channel also owns an 8-bit timer byte. A legal write to a transmit byte produces a one-cycle strobe toward the channel's shifter. A byte that arrives from a channel's receiver is loaded into its receive byte, sets the ready flag and raises a one-cycle receive event. Bit-level shifting, baud timing and interrupt routing are left to neighbouring logic.

Top module: `sio3_regfile`

## Requirements
- R1: Channel n (0..2) decodes at 0x10·n plus a sub-offset: control +0x0, interrupt mode +0x4, transmit +0x8, receive +0x9, status +0xC. The timer byte sits at offset 0x2D. Any other offset, including channel index 3, is an error.
- R2: A control access requires req_wide=1 (16 bits). Interrupt-mode, transmit, receive and timer accesses require req_wide=0 (8 bits). Status reads are legal at 8 bits on every channel and at 16 bits on channels 0 and 1, but not on channel 2.
- R3: A control write to channel 2 that has any bit of 0x0C04 set is refused. Channels 0 and 1 store any control value.
- R4: An interrupt-mode write is refused if it has any bit of 0xCA set on channel 2, or any bit of 0x4A set on channels 0 and 1.
- R5: A byte on rx_data with its rx_valid bit set is loaded into that channel's receive byte. It sets status bit 4 (value 0x0010), and rx_event for that channel is high for the following cycle.
- R6: A legal read of a receive byte returns the stored byte and clears status bit 4.
- R7: A legal transmit write stores the byte, which then reads back and appears on that channel's tx_data lane. tx_strobe for that channel is high for exactly one cycle after the write.
- R8: A write to a receive byte or to a status register is refused.
- R9: A refused access sets rsp_err with rsp_valid and returns rsp_rdata=0. It leaves every register unchanged and raises no strobe.
- R10: After reset, every control, interrupt-mode, transmit, receive, status and timer register reads as zero, and all outputs are low.
- R11: If a byte arrives while the ready flag is set, the receive byte is overwritten and the flag stays set.
- R12: If a byte arrives in the same cycle as a receive read on the same channel, the read returns the earlier byte. The new byte is stored and the flag remains set.
- R13: Every request gives rsp_valid in the following cycle and at no other time. An 8-bit read returns its byte zero-extended, and an 8-bit status read returns the status word's low byte.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 16 | Write data; 8-bit registers take bits 7:0 |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_err | output | 1 | Previous request was refused |
| rsp_rdata | output | 16 | Read data, zero on writes and errors |
| rx_valid | input | 3 | Per-channel byte arrival |
| rx_data | input | 24 | Arriving bytes, channel n on bits 8n+7:8n |
| rx_event | output | 3 | One-cycle pulse per channel after an arrival |
| tx_strobe | output | 3 | One-cycle pulse per channel after a transmit write |
| tx_data | output | 24 | Transmit byte per channel, channel n on bits 8n+7:8n |

## Verification
A receive-byte read and an arriving byte can land on the same channel in the same cycle. The bench provokes this by raising rx_valid on the same falling edge that presents the receive read. It then expects the response to carry the older byte, and expects a later status read and receive read to show the flag still set and the newer byte stored. A second case has two arrivals with no read between them, which checks the overwrite rule on its own.

// File: rtl/sio3_pkg.sv
`timescale 1ns/1ps
package sio3_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_CTRL,
      K_IMODE,
      K_TXB,
      K_RXB,
      K_STAT,
      K_TIMER
   } reg_kind_e;

   // sub-offsets inside one channel window
   localparam logic [3:0] SUB_CTRL  = 4'h0;
   localparam logic [3:0] SUB_IMODE = 4'h4;
   localparam logic [3:0] SUB_TXB   = 4'h8;
   localparam logic [3:0] SUB_RXB   = 4'h9;
   localparam logic [3:0] SUB_STAT  = 4'hC;

   // protected-bit masks
   localparam logic [15:0] CTRL_RO_LAST  = 16'h0C04;
   localparam logic [7:0]  IMODE_RO_STD  = 8'h4A;
   localparam logic [7:0]  IMODE_RO_LAST = 8'hCA;

endpackage

// File: rtl/sio3_decode.sv
`timescale 1ns/1ps
module sio3_decode
   import sio3_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_CH    = 3,
   parameter int CH_STRIDE = 16,
   parameter int HAS_TIMER = 1,
   parameter int TIMER_OFF = 'h2D,
   parameter int CTRL_W    = 16,
   localparam int CH_SHIFT = $clog2(CH_STRIDE),
   localparam int CH_IDX_W = ADDR_W - CH_SHIFT
)(
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wide,
   input  logic                write,
   input  logic [CTRL_W-1:0]   wdata,
   output reg_kind_e           kind,
   output logic [CH_IDX_W-1:0] ch,
   output logic                legal
);
   logic [CH_SHIFT-1:0] sub;
   logic                last_ch;

   assign sub     = addr[CH_SHIFT-1:0];
   assign ch      = addr[ADDR_W-1:CH_SHIFT];
   assign last_ch = (ch == CH_IDX_W'(NUM_CH-1));

   always_comb begin
      kind  = K_NONE;
      legal = 1'b0;
      if (HAS_TIMER != 0 && addr == ADDR_W'(TIMER_OFF)) begin
         kind  = K_TIMER;
         legal = !wide;
      end else if (int'(ch) < NUM_CH) begin
         case (sub)
            CH_SHIFT'(SUB_CTRL): begin
               kind  = K_CTRL;
               legal = wide && !(write && last_ch && |(wdata & CTRL_W'(CTRL_RO_LAST)));
            end
            CH_SHIFT'(SUB_IMODE): begin
               kind  = K_IMODE;
               legal = !wide && !(write &&
                       |(wdata[7:0] & (last_ch ? IMODE_RO_LAST : IMODE_RO_STD)));
            end
            CH_SHIFT'(SUB_TXB): begin
               kind  = K_TXB;
               legal = !wide;
            end
            CH_SHIFT'(SUB_RXB): begin
               kind  = K_RXB;
               legal = !wide && !write;
            end
            CH_SHIFT'(SUB_STAT): begin
               kind  = K_STAT;
               legal = !write && (!wide || !last_ch);
            end
            default: begin
               kind  = K_NONE;
               legal = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/sio3_chan.sv
`timescale 1ns/1ps
module sio3_chan #(
   parameter int DATA_W  = 8,
   parameter int CTRL_W  = 16,
   parameter int STAT_W  = 16,
   parameter int RDY_BIT = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              imode_we,
   input  logic              txb_we,
   input  logic              rxb_rd,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              rx_in_valid,
   input  logic [DATA_W-1:0] rx_in_byte,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] imode_q,
   output logic [DATA_W-1:0] txb_q,
   output logic [DATA_W-1:0] rxb_q,
   output logic [STAT_W-1:0] stat_q,
   output logic              rdy_q,
   output logic              tx_pulse,
   output logic              rx_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         imode_q  <= '0;
         txb_q    <= '0;
         rxb_q    <= '0;
         rdy_q    <= 1'b0;
         tx_pulse <= 1'b0;
         rx_pulse <= 1'b0;
      end else begin
         if (ctrl_we)  ctrl_q  <= wdata;
         if (imode_we) imode_q <= wdata[DATA_W-1:0];
         if (txb_we)   txb_q   <= wdata[DATA_W-1:0];
         tx_pulse <= txb_we;
         rx_pulse <= rx_in_valid;
         // arrival outranks a same-cycle read
         if (rx_in_valid) begin
            rxb_q <= rx_in_byte;
            rdy_q <= 1'b1;
         end else if (rxb_rd) begin
            rdy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      stat_q          = '0;
      stat_q[RDY_BIT] = rdy_q;
   end
endmodule

// File: rtl/sio3_regfile.sv
`timescale 1ns/1ps
module sio3_regfile
   import sio3_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int NUM_CH    = 3,
   parameter int CH_STRIDE = 16,
   parameter int DATA_W    = 8,
   parameter int CTRL_W    = 16,
   parameter int RDY_BIT   = 4,
   parameter int HAS_TIMER = 1,
   parameter int TIMER_OFF = 'h2D
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic                     req_wide,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [CTRL_W-1:0]        req_wdata,
   output logic                     rsp_valid,
   output logic                     rsp_err,
   output logic [CTRL_W-1:0]        rsp_rdata,
   input  logic [NUM_CH-1:0]        rx_valid,
   input  logic [NUM_CH*DATA_W-1:0] rx_data,
   output logic [NUM_CH-1:0]        rx_event,
   output logic [NUM_CH-1:0]        tx_strobe,
   output logic [NUM_CH*DATA_W-1:0] tx_data
);
   localparam int CH_SHIFT = $clog2(CH_STRIDE);
   localparam int CH_IDX_W = ADDR_W - CH_SHIFT;
   localparam int CH_SLOTS = 1 << CH_IDX_W;

   initial begin
      assert ((1 << CH_SHIFT) == CH_STRIDE) else $error("stride must be a power of two");
      assert (NUM_CH <= CH_SLOTS && NUM_CH >= 1) else $error("channel count does not fit the map");
      assert (RDY_BIT < CTRL_W && DATA_W <= CTRL_W) else $error("field widths inconsistent");
   end

   reg_kind_e           dec_kind;
   logic [CH_IDX_W-1:0] dec_ch;
   logic                dec_legal;
   logic                acc_ok;

   sio3_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE),
      .HAS_TIMER(HAS_TIMER), .TIMER_OFF(TIMER_OFF), .CTRL_W(CTRL_W)
   ) u_dec (
      .addr(req_addr), .wide(req_wide), .write(req_write), .wdata(req_wdata),
      .kind(dec_kind), .ch(dec_ch), .legal(dec_legal)
   );

   assign acc_ok = req_valid && dec_legal;

   logic [CTRL_W-1:0] ctrl_a  [CH_SLOTS];
   logic [DATA_W-1:0] imode_a [CH_SLOTS];
   logic [DATA_W-1:0] txb_a   [CH_SLOTS];
   logic [DATA_W-1:0] rxb_a   [CH_SLOTS];
   logic [CTRL_W-1:0] stat_a  [CH_SLOTS];
   logic [NUM_CH-1:0] rdy_vec;
   logic [DATA_W-1:0] timer_q;

   for (genvar g = 0; g < CH_SLOTS; g++) begin : g_ch
      if (g < NUM_CH) begin : g_real
         logic sel;
         assign sel = acc_ok && (dec_ch == CH_IDX_W'(g));
         sio3_chan #(
            .DATA_W(DATA_W), .CTRL_W(CTRL_W), .STAT_W(CTRL_W), .RDY_BIT(RDY_BIT)
         ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we (sel && req_write && dec_kind == K_CTRL),
            .imode_we(sel && req_write && dec_kind == K_IMODE),
            .txb_we  (sel && req_write && dec_kind == K_TXB),
            .rxb_rd  (sel && !req_write && dec_kind == K_RXB),
            .wdata(req_wdata),
            .rx_in_valid(rx_valid[g]),
            .rx_in_byte(rx_data[g*DATA_W +: DATA_W]),
            .ctrl_q(ctrl_a[g]), .imode_q(imode_a[g]), .txb_q(txb_a[g]),
            .rxb_q(rxb_a[g]), .stat_q(stat_a[g]), .rdy_q(rdy_vec[g]),
            .tx_pulse(tx_strobe[g]), .rx_pulse(rx_event[g])
         );
         assign tx_data[g*DATA_W +: DATA_W] = txb_a[g];
      end else begin : g_empty
         assign ctrl_a[g]  = '0;
         assign imode_a[g] = '0;
         assign txb_a[g]   = '0;
         assign rxb_a[g]   = '0;
         assign stat_a[g]  = '0;
      end
   end

   if (HAS_TIMER != 0) begin : g_timer
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            timer_q <= '0;
         else if (acc_ok && req_write && dec_kind == K_TIMER)
            timer_q <= req_wdata[DATA_W-1:0];
      end
   end else begin : g_no_timer
      assign timer_q = '0;
   end

   logic [CTRL_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      case (dec_kind)
         K_CTRL:  rd_word = ctrl_a[dec_ch];
         K_IMODE: rd_word = CTRL_W'(imode_a[dec_ch]);
         K_TXB:   rd_word = CTRL_W'(txb_a[dec_ch]);
         K_RXB:   rd_word = CTRL_W'(rxb_a[dec_ch]);
         K_STAT:  rd_word = req_wide ? stat_a[dec_ch] : CTRL_W'(stat_a[dec_ch][7:0]);
         K_TIMER: rd_word = CTRL_W'(timer_q);
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !dec_legal;
         rsp_rdata <= (acc_ok && !req_write) ? rd_word : '0;
      end
   end
endmodule

// File: rtl/sio3_regfile_chk.sv
`timescale 1ns/1ps
module sio3_regfile_chk #(
   parameter int ADDR_W = 6,
   parameter int NUM_CH = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_wide,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [NUM_CH-1:0] rx_valid,
   input logic [NUM_CH-1:0] rx_event,
   input logic [NUM_CH-1:0] tx_strobe,
   input logic [NUM_CH-1:0] rdy_vec
);
   p_resp_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_no_stray_resp_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_ctrl_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr == ADDR_W'(0) && !req_wide) |=> rsp_err);
   p_rxb_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(9)) |=> rsp_err);
   p_err_has_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);
   p_arrival_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[0] |=> (rdy_vec[0] && rx_event[0]));
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_wide && req_addr == ADDR_W'(9) && !rx_valid[0])
      |=> !rdy_vec[0]);
   p_overwrite_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_vec[0] && rx_valid[0]) |=> rdy_vec[0]);
   p_tx_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe[0] |-> $past(req_valid && req_write && !req_wide && req_addr == ADDR_W'(8)));
endmodule

bind sio3_regfile sio3_regfile_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sio3_regfile_tb.sv
`timescale 1ns/1ps
module sio3_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [15:0] rsp_rdata;
   logic [2:0]  rx_valid = '0;
   logic [23:0] rx_data = '0;
   logic [2:0]  rx_event, tx_strobe;
   logic [23:0] tx_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          err;
      logic [15:0] data;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   sio3_regfile u_dut (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pop one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            chk("R13 unexpected response", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " err"}, 32'(rsp_err), 32'(e.err));
            chk({e.tag, " data"}, 32'(rsp_rdata), 32'(e.data));
         end
      end
   end

   // called at a falling edge; returns at the next one
   task automatic acc(bit wr, bit wide, logic [5:0] a, logic [15:0] d,
                      bit xerr, logic [15:0] xdata, string tag);
      exp_t e;
      req_valid = 1'b1; req_write = wr; req_wide = wide;
      req_addr = a; req_wdata = d;
      e.err = xerr; e.data = xdata; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
   endtask

   task automatic rx(int ch, logic [7:0] b);
      rx_valid[ch] = 1'b1;
      rx_data[ch*8 +: 8] = b;
      @(negedge clk);
      rx_valid = '0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {rsp_valid, rsp_err, rx_event, tx_strobe}, 0);
      chk("R10 reset tx_data", 32'(tx_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset contents
      acc(0, 1, 6'h00, 0, 0, 16'h0000, "R10 ctrl0");
      acc(0, 0, 6'h1C, 0, 0, 16'h0000, "R10 stat1");
      acc(0, 0, 6'h2D, 0, 0, 16'h0000, "R10 timer");
      acc(0, 0, 6'h29, 0, 0, 16'h0000, "R10 rxb2");

      // R1 map
      acc(1, 1, 6'h10, 16'hBEEF, 0, 0, "R1 wr ctrl1");
      acc(0, 1, 6'h10, 0, 0, 16'hBEEF, "R1 rd ctrl1");
      acc(1, 0, 6'h04, 16'h0035, 0, 0, "R1 wr imode0");
      acc(0, 0, 6'h04, 0, 0, 16'h0035, "R1 rd imode0");
      acc(1, 0, 6'h2D, 16'h005A, 0, 0, "R1 wr timer");
      acc(0, 0, 6'h2D, 0, 0, 16'h005A, "R1 rd timer");
      acc(0, 0, 6'h01, 0, 1, 0, "R1 hole offset");
      acc(0, 0, 6'h38, 0, 1, 0, "R1 channel 3");

      // R2 sizes
      acc(0, 0, 6'h00, 0, 1, 0, "R2 ctrl byte");
      acc(0, 1, 6'h04, 0, 1, 0, "R2 imode wide");
      acc(0, 1, 6'h0C, 0, 0, 16'h0000, "R2 stat0 wide");
      acc(0, 1, 6'h2C, 0, 1, 0, "R2 stat2 wide");

      // R3 control masks
      acc(1, 1, 6'h20, 16'h0004, 1, 0, "R3 ctrl2 ro");
      acc(0, 1, 6'h20, 0, 0, 16'h0000, "R3 ctrl2 kept");
      acc(1, 1, 6'h20, 16'h1230, 0, 0, "R3 ctrl2 ok");
      acc(0, 1, 6'h20, 0, 0, 16'h1230, "R3 ctrl2 rd");
      acc(1, 1, 6'h00, 16'hFFFF, 0, 0, "R3 ctrl0 any");
      acc(0, 1, 6'h00, 0, 0, 16'hFFFF, "R3 ctrl0 rd");

      // R4 interrupt-mode masks
      acc(1, 0, 6'h24, 16'h0080, 1, 0, "R4 imode2 ro");
      acc(1, 0, 6'h04, 16'h0080, 0, 0, "R4 imode0 ok");
      acc(0, 0, 6'h04, 0, 0, 16'h0080, "R4 imode0 rd");
      acc(1, 0, 6'h14, 16'h0002, 1, 0, "R4 imode1 ro");
      acc(0, 0, 6'h14, 0, 0, 16'h0000, "R4 imode1 kept");

      // R7 transmit
      acc(1, 0, 6'h18, 16'h0041, 0, 0, "R7 wr txb1");
      chk("R7 strobe", 32'(tx_strobe), 32'b010);
      chk("R7 tx_data lane", 32'(tx_data[15:8]), 32'h41);
      @(negedge clk);
      chk("R7 strobe one cycle", 32'(tx_strobe), 0);
      acc(0, 0, 6'h18, 0, 0, 16'h0041, "R7 rd txb1");

      // R8 / R9 illegal writes
      acc(1, 0, 6'h09, 16'h00AA, 1, 0, "R8 wr rxb0");
      chk("R9 no strobe", 32'(tx_strobe), 0);
      acc(1, 0, 6'h0C, 16'h00FF, 1, 0, "R8 wr stat0");
      acc(1, 1, 6'h08, 16'h0099, 1, 0, "R9 wide txb0");
      chk("R9 no strobe wide", 32'(tx_strobe), 0);
      acc(0, 0, 6'h08, 0, 0, 16'h0000, "R9 txb0 kept");
      acc(0, 0, 6'h0C, 0, 0, 16'h0000, "R9 stat0 kept");

      // R5 / R6 receive
      rx(2, 8'h77);
      chk("R5 rx_event", 32'(rx_event), 32'b100);
      acc(0, 0, 6'h2C, 0, 0, 16'h0010, "R5 stat2 ready");
      acc(0, 0, 6'h29, 0, 0, 16'h0077, "R6 rd rxb2");
      acc(0, 0, 6'h2C, 0, 0, 16'h0000, "R6 stat2 cleared");

      // R11 overwrite
      rx(0, 8'h11);
      rx(0, 8'h22);
      acc(0, 1, 6'h0C, 0, 0, 16'h0010, "R11 stat0 still set");
      acc(0, 0, 6'h09, 0, 0, 16'h0022, "R11 newest byte");

      // R12 arrival during read
      rx(1, 8'h33);
      rx_valid[1] = 1'b1;
      rx_data[15:8] = 8'h44;
      acc(0, 0, 6'h19, 0, 0, 16'h0033, "R12 old byte");
      rx_valid = '0;
      acc(0, 0, 6'h1C, 0, 0, 16'h0010, "R12 flag kept");
      acc(0, 0, 6'h19, 0, 0, 16'h0044, "R12 new byte");
      acc(0, 0, 6'h1C, 0, 0, 16'h0000, "R12 flag cleared");

      repeat (3) @(negedge clk);
      chk("R13 all responses seen", 32'(sb.size()), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule